// File: doc/BRIEF.md
# Serial Configuration Loader for a Target FPGA

This block configures a downstream FPGA through its passive serial pins. It takes a configuration image as a stream of bytes over a valid/ready handshake. On a start pulse it runs a fixed sequence:

1. Pull the target's clear line low.
2. Wait for the target to signal that it is clearing.
3. Release the clear line.
4. Wait for the target to report ready.
5. Shift every byte out on a serial clock/data pair.
6. Wait for the target's configured flag.
7. Issue a short post-load reset pattern on the clock and data lines.

Each handshake wait has its own timeout. A timeout ends the run with a separate error code for each phase. The block can be started again after any outcome.

A host starts a load with `start` and feeds bytes as the block asks for them, marking the final byte. It then reads `busy`, `doneOk` and `errCode`. All bit timing, the three timeout limits and the length of the post-load pattern are parameters counted in clock cycles. The target's status inputs are sampled directly on `clk`, so any resynchronisation belongs to the caller.

Top module: `cfg_loader`

## Requirements
- R1: During and after reset, `tgtClearN` is 1, `busy`, `doneOk`, `inReady`, `serClk` and `serData` are 0, and `errCode` is 0.
- R2: A `start` pulse sampled while idle drives `tgtClearN` low and `busy` high from the next cycle. A `start` pulse while `busy` is high is ignored and the running load completes normally.
- R3: With the clear line low, `tgtRdy` must be seen low within `LIM_CLR` cycles, after which `tgtClearN` returns to 1. Otherwise the run ends with `errCode` = 1 and `tgtClearN` at 1.
- R4: After the clear line is released, `tgtRdy` must be seen high within `LIM_RDY` cycles. Otherwise the run ends with `errCode` = 2.
- R5: `inReady` is 1 only in the shift phase while no byte is being shifted. A byte is taken on a clock edge where `inValid` and `inReady` are both 1. Outside the shift phase no byte is taken.
- R6: Each byte is sent most significant bit first, with one rising `serClk` edge per bit. `serData` settles while `serClk` is low and holds while it is high. `serClk` stays high for `CLK_HALF` cycles per bit.
- R7: After the bit shifting of the byte taken with `inLast` = 1 ends, `tgtConfigured` must be seen high within `LIM_CFG` cycles. Otherwise the run ends with `errCode` = 3.
- R8: After `tgtConfigured` is seen, `serClk` is held high with `serData` low for `SETTLE` cycles, then with `serData` high for `SETTLE` cycles. `tgtClearN` stays 1 throughout. The run then ends with `doneOk` = 1.
- R9: `doneOk` and `errCode` hold their final values while idle until the next accepted `start`, which clears both. A new load after a failed one runs normally.
- R10: The error code is 0 for none, 1 for the clear phase, 2 for the ready phase and 3 for the configured phase. `doneOk` = 1 only with code 0, and neither outcome is shown while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load (one-cycle pulse) |
| inValid | input | 1 | Byte on inData is valid |
| inData | input | DATA_W | Image byte |
| inLast | input | 1 | Byte is the final one of the image |
| inReady | output | 1 | Block takes a byte this cycle if inValid |
| tgtRdy | input | 1 | Target status: low while clearing, high when ready |
| tgtConfigured | input | 1 | Target reports configuration complete |
| tgtClearN | output | 1 | Clear request to target, active low, idles high |
| serClk | output | 1 | Serial configuration clock |
| serData | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| doneOk | output | 1 | Last load succeeded |
| errCode | output | 2 | Last load's failure phase (0 none) |

## Verification
The hardest situations to reach are the exact timeout edges. For each phase, a target answering on the last allowed cycle must pass and one answering a cycle later must fail. The bench models the target as a responder whose reply delay for each of the three phases is swept across the limit, one phase at a time, while the other two phases answer promptly. The configured-phase delay is measured from the falling edge of the last bit's serial clock, so that the window starts where the design starts it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_CLR_STUCK = 2'd1,
    ERR_RDY_STUCK = 2'd2,
    ERR_NO_CONFIG = 2'd3
  } cfgErr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_WAIT_RDY,
    ST_SHIFT,
    ST_WAIT_CFG,
    ST_SETTLE_LO,
    ST_SETTLE_HI
  } cfgState_e;

  typedef struct packed {
    logic loadByte;
    logic timerClr;
    logic clkHold;
    logic dataHold;
  } dpCtl_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CLK_HALF = 4,
  parameter int TMR_W    = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] byteIn,
  output logic              engBusy,
  output logic              byteDone,
  output logic [TMR_W-1:0]  tmr,
  output logic              serClk,
  output logic              serData
);

  localparam int PH_W  = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] shReg;
  logic [BIT_W-1:0]  bitIdx;
  logic [PH_W-1:0]   phaseCnt;
  logic              clkR;
  logic              active;
  logic              phaseEnd;
  logic              lastBit;

  assign phaseEnd = (phaseCnt == PH_W'(CLK_HALF - 1));
  assign lastBit  = (bitIdx == BIT_W'(DATA_W - 1));
  assign byteDone = active && clkR && phaseEnd && lastBit;
  assign engBusy  = active;

  // bit engine: low phase then high phase per bit, shift on falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitIdx   <= '0;
      phaseCnt <= '0;
      clkR     <= 1'b0;
      active   <= 1'b0;
    end else if (ctl.loadByte) begin
      shReg    <= byteIn;
      bitIdx   <= '0;
      phaseCnt <= '0;
      clkR     <= 1'b0;
      active   <= 1'b1;
    end else if (active) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        if (!clkR) begin
          clkR <= 1'b1;
        end else begin
          clkR   <= 1'b0;
          shReg  <= {shReg[DATA_W-2:0], 1'b0};
          bitIdx <= bitIdx + 1'b1;
          if (lastBit) active <= 1'b0;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // shared phase timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tmr <= '0;
    else if (ctl.timerClr) tmr <= '0;
    else if (tmr != '1)    tmr <= tmr + 1'b1;
  end

  assign serClk  = ctl.clkHold | clkR;
  assign serData = ctl.clkHold ? ctl.dataHold : (active & shReg[DATA_W-1]);

  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkR && $past(clkR)) |-> $stable(shReg[DATA_W-1]));

  // R5
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadByte |-> !active);

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int LIM_CLR = 1024,
  parameter int LIM_RDY = 1024,
  parameter int LIM_CFG = 65536,
  parameter int SETTLE  = 100000,
  parameter int TMR_W   = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             tgtRdy,
  input  logic             tgtConfigured,
  input  logic             engBusy,
  input  logic             byteDone,
  input  logic [TMR_W-1:0] tmr,
  output dpCtl_t           ctl,
  output logic             inReady,
  output logic             tgtClearN,
  output logic             busy,
  output logic             doneOk,
  output logic [1:0]       errCode
);

  cfgState_e st, stNext;
  cfgErr_e   errR, errNext;
  logic      okR, okNext;
  logic      lastPend;
  logic      take;

  always_comb begin
    stNext  = st;
    errNext = errR;
    okNext  = okR;
    ctl     = '0;
    inReady = 1'b0;
    take    = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        stNext       = ST_CLEAR;
        ctl.timerClr = 1'b1;
        errNext      = ERR_NONE;
        okNext       = 1'b0;
      end
      ST_CLEAR: if (!tgtRdy) begin
        stNext       = ST_WAIT_RDY;
        ctl.timerClr = 1'b1;
      end else if (tmr == TMR_W'(LIM_CLR - 1)) begin
        stNext  = ST_IDLE;
        errNext = ERR_CLR_STUCK;
      end
      ST_WAIT_RDY: if (tgtRdy) begin
        stNext = ST_SHIFT;
      end else if (tmr == TMR_W'(LIM_RDY - 1)) begin
        stNext  = ST_IDLE;
        errNext = ERR_RDY_STUCK;
      end
      ST_SHIFT: begin
        inReady = !engBusy;
        take    = inValid && !engBusy;
        ctl.loadByte = take;
        if (byteDone && lastPend) begin
          stNext       = ST_WAIT_CFG;
          ctl.timerClr = 1'b1;
        end
      end
      ST_WAIT_CFG: if (tgtConfigured) begin
        stNext       = ST_SETTLE_LO;
        ctl.timerClr = 1'b1;
      end else if (tmr == TMR_W'(LIM_CFG - 1)) begin
        stNext  = ST_IDLE;
        errNext = ERR_NO_CONFIG;
      end
      ST_SETTLE_LO: begin
        ctl.clkHold = 1'b1;
        if (tmr == TMR_W'(SETTLE - 1)) begin
          stNext       = ST_SETTLE_HI;
          ctl.timerClr = 1'b1;
        end
      end
      ST_SETTLE_HI: begin
        ctl.clkHold  = 1'b1;
        ctl.dataHold = 1'b1;
        if (tmr == TMR_W'(SETTLE - 1)) begin
          stNext = ST_IDLE;
          okNext = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      errR     <= ERR_NONE;
      okR      <= 1'b0;
      lastPend <= 1'b0;
    end else begin
      st   <= stNext;
      errR <= errNext;
      okR  <= okNext;
      if (take) lastPend <= inLast;
    end
  end

  assign tgtClearN = (st != ST_CLEAR);
  assign busy      = (st != ST_IDLE);
  assign doneOk    = okR;
  assign errCode   = errR;

  // R3
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tgtClearN |-> busy);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && !engBusy));

  // R10
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> (errCode == 2'd0 && !busy));

  // R10
  busy_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!doneOk && errCode == 2'd0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(errCode) && $stable(doneOk)));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CLK_HALF = 4,
  parameter int LIM_CLR  = 1024,
  parameter int LIM_RDY  = 1024,
  parameter int LIM_CFG  = 65536,
  parameter int SETTLE   = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  input  logic              tgtRdy,
  input  logic              tgtConfigured,
  output logic              tgtClearN,
  output logic              serClk,
  output logic              serData,
  output logic              busy,
  output logic              doneOk,
  output logic [1:0]        errCode
);

  localparam int MAX_A = (LIM_CLR > LIM_RDY) ? LIM_CLR : LIM_RDY;
  localparam int MAX_B = (LIM_CFG > SETTLE) ? LIM_CFG : SETTLE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_T + 1);

  dpCtl_t           ctl;
  logic             engBusy;
  logic             byteDone;
  logic [TMR_W-1:0] tmr;

  cfg_loader_ctrl #(
    .LIM_CLR(LIM_CLR), .LIM_RDY(LIM_RDY), .LIM_CFG(LIM_CFG),
    .SETTLE(SETTLE), .TMR_W(TMR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inLast(inLast), .tgtRdy(tgtRdy), .tgtConfigured(tgtConfigured),
    .engBusy(engBusy), .byteDone(byteDone), .tmr(tmr), .ctl(ctl),
    .inReady(inReady), .tgtClearN(tgtClearN), .busy(busy),
    .doneOk(doneOk), .errCode(errCode)
  );

  cfg_loader_dp #(
    .DATA_W(DATA_W), .CLK_HALF(CLK_HALF), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteIn(inData),
    .engBusy(engBusy), .byteDone(byteDone), .tmr(tmr),
    .serClk(serClk), .serData(serData)
  );

endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;

  localparam int HALF = 2;
  localparam int LCLR = 4;
  localparam int LRDY = 5;
  localparam int LCFG = 6;
  localparam int STL  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0;
  logic       tgtRdy = 1'b1;
  logic       tgtConfigured = 1'b0;
  logic       inReady, tgtClearN, serClk, serData, busy, doneOk;
  logic [1:0] errCode;

  int checks = 0;
  int errors = 0;

  int capCnt;
  bit capBits [0:31];

  always #5 clk = ~clk;

  cfg_loader #(
    .DATA_W(8), .CLK_HALF(HALF), .LIM_CLR(LCLR), .LIM_RDY(LRDY),
    .LIM_CFG(LCFG), .SETTLE(STL)
  ) u_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inReady(inReady),
    .tgtRdy(tgtRdy), .tgtConfigured(tgtConfigured),
    .tgtClearN(tgtClearN), .serClk(serClk), .serData(serData),
    .busy(busy), .doneOk(doneOk), .errCode(errCode)
  );

  always @(posedge serClk) begin
    if (!tgtConfigured) begin
      if (capCnt < 32) capBits[capCnt] = serData;
      capCnt = capCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_trial(input int d1, input int d2, input int d3,
                           input int nb, input int seed, input bit midStart);
    logic [7:0] bytes [4];
    int expErr;
    int hiCnt = 0;
    int postLo = 0;
    int postHi = 0;
    int badClr = 0;
    int expBits;
    int bitErr = 0;
    logic [1:0] holdErr;
    logic holdOk;

    for (int i = 0; i < 4; i++) bytes[i] = 8'((seed * 37 + i * 91 + 5) & 255);
    if (d1 >= LCLR)      expErr = 1;
    else if (d2 >= LRDY) expErr = 2;
    else if (d3 >= LCFG) expErr = 3;
    else                 expErr = 0;
    expBits = (expErr == 0 || expErr == 3) ? 8 * nb : 0;
    capCnt = 0;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(tgtClearN == 1'b0, "R2 clear low after start", int'(tgtClearN), 0);
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(inReady == 1'b0, "R5 no ready in clear phase", int'(inReady), 0);

    fork
      begin : responder
        bit drove = 1'b0;
        repeat (d1) @(negedge clk);
        if (tgtClearN == 1'b0) begin tgtRdy = 1'b0; drove = 1'b1; end
        if (drove) begin
          wait (tgtClearN == 1'b1);
          repeat (d2) @(negedge clk);
          @(negedge clk);
          if (busy) begin
            tgtRdy = 1'b1;
            for (int b = 0; b < 8 * nb; b++) @(posedge serClk);
            @(negedge serClk);
            repeat (d3) @(negedge clk);
            @(negedge clk);
            if (busy) tgtConfigured = 1'b1;
          end
        end
      end
      begin : feeder
        for (int i = 0; i < nb; i++) begin
          @(negedge clk);
          while (!inReady && busy) @(negedge clk);
          if (!busy) break;
          inValid = 1'b1;
          inData  = bytes[i];
          inLast  = (i == nb - 1);
          @(negedge clk);
          inValid = 1'b0;
          inLast  = 1'b0;
          if (midStart && i == 0) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
          end
        end
      end
      begin : waiter
        while (busy) begin
          @(negedge clk);
          if (busy && tgtConfigured) begin
            if (serClk && !serData) postLo++;
            if (serClk && serData)  postHi++;
            if (!tgtClearN)         badClr++;
          end else if (busy && serClk) begin
            hiCnt++;
          end
        end
      end
    join

    check(int'(errCode) == expErr,
          (expErr == 1) ? "R3 clear timeout code" :
          (expErr == 2) ? "R4 ready timeout code" :
          (expErr == 3) ? "R7 configured timeout code" : "R10 no error code",
          int'(errCode), expErr);
    check(doneOk == (expErr == 0), "R8 doneOk outcome", int'(doneOk), int'(expErr == 0));
    check(tgtClearN == 1'b1, "R3 clear released at end", int'(tgtClearN), 1);
    check(capCnt == expBits, "R6 serial clock rises", capCnt, expBits);
    if (capCnt == expBits) begin
      for (int b = 0; b < expBits; b++)
        if (capBits[b] != bytes[b / 8][7 - (b % 8)]) bitErr++;
      check(bitErr == 0, "R6 bits MSB first", bitErr, 0);
    end
    check(hiCnt == expBits * HALF, "R6 clock high time", hiCnt, expBits * HALF);
    if (expErr == 0) begin
      check(postLo == STL, "R8 settle with data low", postLo, STL);
      check(postHi == STL, "R8 settle with data high", postHi, STL);
      check(badClr == 0, "R8 clear line high in settle", badClr, 0);
    end
    holdErr = errCode;
    holdOk  = doneOk;
    repeat (4) @(negedge clk);
    check(errCode == holdErr, "R9 error code held", int'(errCode), int'(holdErr));
    check(doneOk == holdOk, "R9 doneOk held", int'(doneOk), int'(holdOk));
    check(inReady == 1'b0, "R5 no ready while idle", int'(inReady), 0);
    tgtRdy = 1'b1;
    tgtConfigured = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tgtClearN == 1'b1, "R1 clear high in reset", int'(tgtClearN), 1);
    check(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && doneOk == 1'b0, "R1 idle after reset", int'({busy, doneOk}), 0);
    check(errCode == 2'd0, "R1 error code after reset", int'(errCode), 0);
    check(inReady == 1'b0 && serClk == 1'b0 && serData == 1'b0,
          "R1 serial idle", int'({inReady, serClk, serData}), 0);

    // clear-phase delay swept across its limit (R3)
    for (int d = 0; d <= LCLR + 1; d++) run_trial(d, 1, 1, 1 + d % 3, d, 1'b0);
    // ready-phase delay swept across its limit (R4)
    for (int d = 0; d <= LRDY + 1; d++) run_trial(2, d, 1, 1 + d % 3, 10 + d, 1'b0);
    // configured-phase delay swept across its limit (R7)
    for (int d = 0; d <= LCFG + 1; d++) run_trial(1, 2, d, 1 + d % 4, 20 + d, 1'b0);
    // start pulse during shifting is ignored (R2)
    run_trial(0, 0, 0, 3, 41, 1'b1);
    // restart after a failure (R9)
    run_trial(LCLR, 0, 0, 1, 42, 1'b0);
    run_trial(0, 0, 0, 2, 43, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule